// File: doc/BRIEF.md
# Watchpoint-Driven Breakpoint Down Counter

This block holds two independent down counters. Each one is programmed with a start value and a watchpoint source, and it counts occurrences of the chosen watchpoint. The source is one of the instruction watchpoint pulses or one of the load/store watchpoint pulses. When the count runs out, the counter raises a breakpoint request and holds it until software programs that counter again.

The two source kinds end differently. An instruction watchpoint that arrives while the count is one raises the breakpoint and leaves the count at one. This is because the instruction that would have consumed the last count is never executed. A load/store watchpoint takes the count down to zero and raises the breakpoint in the same step. A counter holding zero is idle.

In masked mode, events that arrive while the recoverable-interrupt status bit is low are not counted.

Top module: `brk_countdown`

## Requirements
- R1: After reset every counter value reads 0 and every breakpoint request is low.
- R2: A write, with `wr_en[i]` high for one cycle, loads `wr_value` into counter i. It also sets the counter's source class (`wr_src_ls` = 0 for instruction, 1 for load/store) and its source index `wr_sel`, and clears breakpoint request i. All of this is visible on the outputs one clock after the write.
- R3: Each cycle in which the selected event is high lowers a nonzero, non-breaking counter by one, visible one clock later. The selected event is `iw_evt[wr_sel]` for the instruction class and `lw_evt[wr_sel]` for the load/store class. A load/store index of `NUM_LW` or above selects no event. Pulses on unselected events have no effect.
- R4: In the instruction class, a selected event while the count is 1 sets the breakpoint request one clock later and leaves the count at 1.
- R5: In the load/store class, a selected event while the count is 1 takes the count to 0 and sets the breakpoint request, both one clock later.
- R6: A counter loaded with 0 stays at 0 and never raises its breakpoint request, whatever events arrive.
- R7: While `mask_en` is 1 and `ri_status` is 0, events are not counted. While `mask_en` is 0, `ri_status` has no effect.
- R8: Once a breakpoint request is set, it stays set and the count stays frozen, through any events, until the counter is written again.
- R9: A write and a selected event in the same cycle leave the counter holding the written value, not one less, with the breakpoint request clear.
- R10: Each counter follows only its own source and write enable; activity on one never changes the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iw_evt | input | NUM_IW | Instruction watchpoint pulses |
| lw_evt | input | NUM_LW | Load/store watchpoint pulses |
| ri_status | input | 1 | Recoverable-interrupt status of the current context |
| mask_en | input | 1 | Masked mode: gate counting on `ri_status` |
| wr_en | input | NUM_CNT | Per-counter write strobe |
| wr_value | input | CNT_W | Start value for the written counter |
| wr_src_ls | input | 1 | Source class of the written counter: 0 instruction, 1 load/store |
| wr_sel | input | SEL_W | Source index within the class |
| brk_req | output | NUM_CNT | Breakpoint request for each counter |
| cnt_value | output | NUM_CNT*CNT_W | Current counts, counter i in bits [i*CNT_W +: CNT_W] |

## Verification
Every result is registered once, so the count and breakpoint effects of a write or an event appear one clock after the edge that samples them. The bench changes its inputs on the falling edge, lets exactly one rising edge pass, and compares the outputs on the next falling edge. No result is therefore read early or late.

The bench sweeps every source index of both classes, start values 1 to 4, and one event beyond run-out. It computes the expected count as the start value minus the events seen, floored at 1 for the instruction class and at 0 for the load/store class.

// File: rtl/brk_cnt_pkg.sv
package brk_cnt_pkg;
  typedef enum logic {
    SRC_INSTR = 1'b0,
    SRC_LDST  = 1'b1
  } src_kind_e;
endpackage

// File: rtl/brk_evt_select.sv
module brk_evt_select
  import brk_cnt_pkg::*;
#(
  parameter int unsigned NUM_IW = 4,
  parameter int unsigned NUM_LW = 2,
  parameter int unsigned SEL_W  = 2
) (
  input  logic [NUM_IW-1:0] iw_evt,
  input  logic [NUM_LW-1:0] lw_evt,
  input  logic              ri_status,
  input  logic              mask_en,
  input  src_kind_e         src,
  input  logic [SEL_W-1:0]  sel,
  output logic              ctx_block,
  output logic              hit
);
  logic raw_hit;

  always_comb begin
    raw_hit = 1'b0;
    if (src == SRC_INSTR) begin
      if (int'(sel) < NUM_IW) raw_hit = iw_evt[sel];
    end else begin
      if (int'(sel) < NUM_LW) raw_hit = lw_evt[sel];
    end
  end

  assign ctx_block = mask_en & ~ri_status;
  assign hit       = raw_hit & ~ctx_block;
endmodule

// File: rtl/brk_count_unit.sv
module brk_count_unit
  import brk_cnt_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_value,
  input  src_kind_e        wr_src,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             hit,
  input  logic             ctx_block,
  output src_kind_e        src,
  output logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] count,
  output logic             brk
);
  logic live;
  logic consume;
  logic last_one;

  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c,
                                                   input src_kind_e s);
    if (s == SRC_INSTR && c == CNT_W'(1)) return c;
    return c - CNT_W'(1);
  endfunction

  function automatic logic runs_out(input logic [CNT_W-1:0] c);
    return c == CNT_W'(1);
  endfunction

  assign live     = (count != '0) && !brk;
  assign consume  = hit && live && !wr_en;
  assign last_one = runs_out(count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      brk   <= 1'b0;
      src   <= SRC_INSTR;
      sel   <= '0;
    end else if (wr_en) begin
      count <= wr_value;
      brk   <= 1'b0;
      src   <= wr_src;
      sel   <= wr_sel;
    end else if (consume) begin
      count <= step_count(count, src);
      if (last_one) brk <= 1'b1;
    end
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (count == $past(wr_value)) && !brk);  // R2 R9
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && count > CNT_W'(1)) |=> count == CNT_W'($past(count) - CNT_W'(1)));  // R3
  AST_INSTR_STAYS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && count == CNT_W'(1) && src == SRC_INSTR) |=> (count == CNT_W'(1)) && brk);  // R4
  AST_LDST_HITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && count == CNT_W'(1) && src == SRC_LDST) |=> (count == '0) && brk);  // R5
  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !brk && !wr_en) |=> (count == '0) && !brk);  // R6
  AST_MASK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_block && !wr_en) |=> $stable(count) && $stable(brk));  // R7
  AST_BRK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && !wr_en) |=> brk && $stable(count));  // R8
endmodule

// File: rtl/brk_countdown.sv
module brk_countdown
  import brk_cnt_pkg::*;
#(
  parameter int unsigned NUM_CNT = 2,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_IW  = 4,
  parameter int unsigned NUM_LW  = 2,
  localparam int unsigned MAX_SRC = (NUM_IW > NUM_LW) ? NUM_IW : NUM_LW,
  localparam int unsigned SEL_W   = (MAX_SRC > 2) ? $clog2(MAX_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_IW-1:0]        iw_evt,
  input  logic [NUM_LW-1:0]        lw_evt,
  input  logic                     ri_status,
  input  logic                     mask_en,
  input  logic [NUM_CNT-1:0]       wr_en,
  input  logic [CNT_W-1:0]         wr_value,
  input  logic                     wr_src_ls,
  input  logic [SEL_W-1:0]         wr_sel,
  output logic [NUM_CNT-1:0]       brk_req,
  output logic [NUM_CNT*CNT_W-1:0] cnt_value
);
  src_kind_e wr_src;
  assign wr_src = wr_src_ls ? SRC_LDST : SRC_INSTR;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    src_kind_e        src;
    logic [SEL_W-1:0] sel;
    logic             hit;
    logic             ctx_block;
    logic [CNT_W-1:0] count;
    logic             brk;

    brk_evt_select #(
      .NUM_IW(NUM_IW), .NUM_LW(NUM_LW), .SEL_W(SEL_W)
    ) u_sel (
      .iw_evt(iw_evt), .lw_evt(lw_evt), .ri_status(ri_status),
      .mask_en(mask_en), .src(src), .sel(sel),
      .ctx_block(ctx_block), .hit(hit)
    );

    brk_count_unit #(
      .CNT_W(CNT_W), .SEL_W(SEL_W)
    ) u_unit (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en[g]), .wr_value(wr_value),
      .wr_src(wr_src), .wr_sel(wr_sel), .hit(hit), .ctx_block(ctx_block),
      .src(src), .sel(sel), .count(count), .brk(brk)
    );

    assign brk_req[g]                   = brk;
    assign cnt_value[g*CNT_W +: CNT_W]  = count;
  end
endmodule

// File: tb/brk_countdown_bench.sv
module brk_countdown_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 2;
  localparam int CW = 16;
  localparam int NI = 4;
  localparam int NL = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NI-1:0] iw_evt = '0;
  logic [NL-1:0] lw_evt = '0;
  logic ri_status = 1'b1;
  logic mask_en = 1'b0;
  logic [NC-1:0] wr_en = '0;
  logic [CW-1:0] wr_value = '0;
  logic wr_src_ls = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [NC-1:0] brk_req;
  logic [NC*CW-1:0] cnt_value;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brk_countdown #(.NUM_CNT(NC), .CNT_W(CW), .NUM_IW(NI), .NUM_LW(NL)) u_brk_countdown (
    .clk(clk), .rst_n(rst_n), .iw_evt(iw_evt), .lw_evt(lw_evt),
    .ri_status(ri_status), .mask_en(mask_en), .wr_en(wr_en),
    .wr_value(wr_value), .wr_src_ls(wr_src_ls), .wr_sel(wr_sel),
    .brk_req(brk_req), .cnt_value(cnt_value)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    iw_evt = '0;
    lw_evt = '0;
    wr_en  = '0;
  endtask

  task automatic chk(input string tag, input int c, input int ec, input bit eb);
    int ac;
    bit ab;
    ac = int'(cnt_value[c*CW +: CW]);
    ab = brk_req[c];
    n_chk++;
    if (ac != ec || ab != eb) begin
      n_fail++;
      $display("FAIL %s counter%0d: count=%0d brk=%0b expected count=%0d brk=%0b",
               tag, c, ac, ab, ec, eb);
    end
  endtask

  task automatic wr(input int c, input int v, input bit ls, input int s);
    wr_en = '0;
    wr_en[c] = 1'b1;
    wr_value = CW'(v);
    wr_src_ls = ls;
    wr_sel = 2'(s);
    tick();
  endtask

  task automatic ev(input logic [NI-1:0] i, input logic [NL-1:0] l);
    iw_evt = i;
    lw_evt = l;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", 0, 0, 0);
    chk("R1 reset", 1, 0, 0);

    // R2 R3 R4 R5 sweep: every source index, start values 1..4
    for (int c = 0; c < NC; c++) begin
      for (int ls = 0; ls < 2; ls++) begin
        for (int s = 0; s < (ls ? NL + 1 : NI); s++) begin
          for (int n = 1; n <= 4; n++) begin
            logic [NI-1:0] pi;
            logic [NL-1:0] pl;
            logic [NI-1:0] ni;
            logic [NL-1:0] nl;
            wr(1 - c, 0, 0, 0);
            wr(c, n, bit'(ls), s);
            chk("R2 load", c, n, 0);
            pi = '0; pl = '0;
            if (ls == 0) pi[s] = 1'b1;
            else if (s < NL) pl[s] = 1'b1;
            ni = ~pi;
            nl = ~pl;
            if (ls == 1) ni = '1;
            else nl = '1;
            ev(ni, nl);
            chk("R3 unselected ignored", c, (ls == 1 && s >= NL) ? n : n, 0);
            for (int k = 1; k <= n + 1; k++) begin
              int ec;
              bit eb;
              ev(pi, pl);
              if (ls == 1 && s >= NL) begin
                ec = n; eb = 0;
              end else if (ls == 0) begin
                ec = (k >= n) ? 1 : n - k; eb = (k >= n);
              end else begin
                ec = (k >= n) ? 0 : n - k; eb = (k >= n);
              end
              if (k < n) chk("R3 step", c, ec, eb);
              else if (ls == 0) chk("R4 instr stop at one", c, ec, eb);
              else chk("R5 ldst to zero", c, ec, eb);
            end
          end
        end
      end
    end

    // R6 zero load disabled
    wr(0, 0, 0, 0);
    wr(1, 0, 1, 0);
    for (int k = 0; k < 3; k++) ev('1, '1);
    chk("R6 zero idle", 0, 0, 0);
    chk("R6 zero idle", 1, 0, 0);

    // R7 masked mode
    wr(0, 3, 0, 2);
    mask_en = 1'b1; ri_status = 1'b0;
    ev(4'b0100, '0);
    chk("R7 masked not counted", 0, 3, 0);
    ri_status = 1'b1;
    ev(4'b0100, '0);
    chk("R7 masked ri high counts", 0, 2, 0);
    mask_en = 1'b0; ri_status = 1'b0;
    ev(4'b0100, '0);
    chk("R7 unmasked ri ignored", 0, 1, 0);
    ri_status = 1'b1;

    // R8 held breakpoint
    ev(4'b0100, '0);
    chk("R8 instr brk set", 0, 1, 1);
    for (int k = 0; k < 3; k++) ev('1, '1);
    chk("R8 instr brk held", 0, 1, 1);
    wr(1, 1, 1, 1);
    ev('0, 2'b10);
    chk("R8 ldst brk set", 1, 0, 1);
    ev('1, '1);
    chk("R8 ldst brk held", 1, 0, 1);
    wr(0, 5, 0, 2);
    chk("R8 rewrite clears", 0, 5, 0);

    // R9 write beats same-cycle event
    iw_evt = 4'b0100;
    wr(0, 9, 0, 2);
    chk("R9 write priority", 0, 9, 0);
    lw_evt = 2'b10;
    wr(1, 7, 1, 1);
    chk("R9 write clears brk", 1, 7, 0);

    // R10 independence
    wr(0, 3, 0, 0);
    wr(1, 5, 1, 1);
    ev(4'b0001, '0);
    ev(4'b0001, '0);
    chk("R10 own source", 0, 1, 0);
    chk("R10 other untouched", 1, 5, 0);
    ev('0, 2'b10);
    chk("R10 own source", 1, 4, 0);
    chk("R10 other untouched", 0, 1, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule